// File: doc/BRIEF.md
# Single-Cycle Execute Unit for a 16-bit CPU

This block is the execute stage of a small 16-bit processor with eight general registers. On each clock edge where its enable is high, it takes a 5-bit operation word, two register operands and an immediate. It then registers four outputs: the result word, a register-write request, a branch-taken indication and a branch target. The operation word holds a 4-bit opcode in bits 4..1. Bit 0 is a modifier flag that changes the behaviour of three opcodes. It picks the byte lane of an immediate load, the signedness of a compare, and the source of a jump target.

The immediate reaches the unit as its 8-bit value copied into both bytes of the 16-bit input. The unit keeps the byte it needs and clears the other one. For memory operations the unit does not touch memory. It passes operand A out as the word address, and the surrounding logic takes the store data from operand B. The register file, memory, fetch, the program counter and hazard handling all sit outside this block.

Top module: `alu16_exec`

## Requirements
- R1: While the active-low reset is low, result, branchTarget, branchTaken and regWrite are all zero.
- R2: Outputs change only on a rising clock edge where en is high. With en low, all four outputs hold their values whatever the other inputs do.
- R3: Opcodes 0000 ADD, 0001 SUB (A minus B), 0010 OR, 0011 XOR and 0100 AND combine A and B. Opcode 0101 NOT inverts A. Arithmetic wraps modulo 2^16. The result appears on the edge that samples the operation.
- R4: Opcode 1010 shifts A left and opcode 1011 shifts A right. Both are logical shifts with zero fill. The shift amount is B[3:0], and the upper bits of B are ignored.
- R5: Opcode 1000 LOAD with flag 1 gives the upper byte of the immediate in result[15:8] with result[7:0] zero. With flag 0 it gives the lower byte in result[7:0] with result[15:8] zero.
- R6: Opcode 1001 CMP puts status bits in the result and clears every other bit. Bit 0 is A equals B, bit 1 is A greater than B, bit 2 is A less than B, bit 3 is A equal to zero, and bit 4 is B equal to zero. Flag 1 compares the operands as two's-complement values and flag 0 compares them as unsigned values.
- R7: Opcode 0110 READ and opcode 0111 WRITE both place operand A, the word address, on the result.
- R8: Opcode 1100 JUMP always sets branchTaken. The target is the immediate when the flag is 1 and operand A when the flag is 0. Whenever branchTaken is 0, branchTarget is zero. Non-branch operations give branchTaken 0.
- R9: Opcode 1101 JUMPEQ sets branchTaken exactly when B[0] (the equal bit of a compare result) is 1, and then uses A as the target. JUMP and JUMPEQ give a zero result.
- R10: regWrite is 0 for WRITE, JUMP and JUMPEQ and 1 for the other defined opcodes.
- R11: Reserved opcodes 1110 and 1111 give a zero result, branchTaken 0 and regWrite 0, whatever the flag is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Captures a new operation on the edge when high |
| aluOp | input | 5 | Opcode in bits 4..1, modifier flag in bit 0 |
| opA | input | 16 | First register operand |
| opB | input | 16 | Second register operand |
| immVal | input | 16 | 8-bit immediate copied into both bytes |
| result | output | 16 | Registered result word |
| branchTaken | output | 1 | Registered branch-taken indication |
| branchTarget | output | 16 | Registered branch target, zero when not taken |
| regWrite | output | 1 | Registered register-write request |

## Verification
The bench builds the unit with its default 16-bit data width. This makes the full 4-bit shift range reachable, so it can drive shifts of 0 and 15 and amounts with upper B bits set. At this width it also places the sign bit at bit 15, where signed and unsigned compares of 0x8000 against 0x0001 give opposite orderings. Directed vectors cover carry wrap, both load lanes, both jump sources and both reserved codes under either flag. A long run of random operations follows, with en toggled at random, and every output is compared against the bench's model on each cycle.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD   = 4'd0,
    OPC_SUB   = 4'd1,
    OPC_OR    = 4'd2,
    OPC_XOR   = 4'd3,
    OPC_AND   = 4'd4,
    OPC_NOT   = 4'd5,
    OPC_READ  = 4'd6,
    OPC_WRITE = 4'd7,
    OPC_LOAD  = 4'd8,
    OPC_CMP   = 4'd9,
    OPC_SHL   = 4'd10,
    OPC_SHR   = 4'd11,
    OPC_JMP   = 4'd12,
    OPC_JMPEQ = 4'd13,
    OPC_RSV0  = 4'd14,
    OPC_RSV1  = 4'd15
  } opcode_e;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_ADD,
    SEL_SUB,
    SEL_OR,
    SEL_XOR,
    SEL_AND,
    SEL_NOT,
    SEL_PASSA,
    SEL_LOAD,
    SEL_CMP,
    SEL_SHL,
    SEL_SHR
  } resSel_e;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    resSel_e resSel;
    logic    wrReg;
    logic    jumpAlways;
    logic    jumpCond;
    logic    tgtImm;
    logic    cmpSigned;
    logic    loadHigh;
  } ctrlStrobes_t;

  // Status bit positions in the compare result
  localparam int CMP_EQ_BIT    = 0;
  localparam int CMP_GT_BIT    = 1;
  localparam int CMP_LT_BIT    = 2;
  localparam int CMP_AZERO_BIT = 3;
  localparam int CMP_BZERO_BIT = 4;
  localparam int CMP_BITS      = 5;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
#(
  parameter int OP_W = OPC_W + 1
) (
  input  logic [OP_W-1:0] aluOp,
  output ctrlStrobes_t    strobes
);

  opcode_e opc;
  logic    modFlag;

  assign opc     = opcode_e'(aluOp[OP_W-1:1]);
  assign modFlag = aluOp[0];

  always_comb begin
    strobes            = '0;
    strobes.resSel     = SEL_ZERO;
    strobes.cmpSigned  = modFlag;
    strobes.loadHigh   = modFlag;
    strobes.tgtImm     = modFlag;
    unique case (opc)
      OPC_ADD:   begin strobes.resSel = SEL_ADD;   strobes.wrReg = 1'b1; end
      OPC_SUB:   begin strobes.resSel = SEL_SUB;   strobes.wrReg = 1'b1; end
      OPC_OR:    begin strobes.resSel = SEL_OR;    strobes.wrReg = 1'b1; end
      OPC_XOR:   begin strobes.resSel = SEL_XOR;   strobes.wrReg = 1'b1; end
      OPC_AND:   begin strobes.resSel = SEL_AND;   strobes.wrReg = 1'b1; end
      OPC_NOT:   begin strobes.resSel = SEL_NOT;   strobes.wrReg = 1'b1; end
      OPC_READ:  begin strobes.resSel = SEL_PASSA; strobes.wrReg = 1'b1; end
      OPC_WRITE: begin strobes.resSel = SEL_PASSA; end
      OPC_LOAD:  begin strobes.resSel = SEL_LOAD;  strobes.wrReg = 1'b1; end
      OPC_CMP:   begin strobes.resSel = SEL_CMP;   strobes.wrReg = 1'b1; end
      OPC_SHL:   begin strobes.resSel = SEL_SHL;   strobes.wrReg = 1'b1; end
      OPC_SHR:   begin strobes.resSel = SEL_SHR;   strobes.wrReg = 1'b1; end
      OPC_JMP:   begin strobes.jumpAlways = 1'b1; end
      OPC_JMPEQ: begin strobes.jumpCond = 1'b1; strobes.tgtImm = 1'b0; end
      default:   begin strobes.resSel = SEL_ZERO; end
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immVal,
  output logic [DATA_W-1:0] result,
  output logic              branchTaken,
  output logic [DATA_W-1:0] branchTarget,
  output logic              regWrite
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  logic [SH_W-1:0]   shAmt;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] cmpVal;
  logic [DATA_W-1:0] nextResult;
  logic [DATA_W-1:0] nextTarget;
  logic              nextTaken;
  logic              aGreater;
  logic              aLess;

  assign shAmt = opB[SH_W-1:0];

  assign loadVal = strobes.loadHigh ? {immVal[DATA_W-1:HALF_W], {HALF_W{1'b0}}}
                                    : {{(DATA_W-HALF_W){1'b0}}, immVal[HALF_W-1:0]};

  always_comb begin
    if (strobes.cmpSigned) begin
      aGreater = $signed(opA) > $signed(opB);
      aLess    = $signed(opA) < $signed(opB);
    end else begin
      aGreater = opA > opB;
      aLess    = opA < opB;
    end
    cmpVal                = '0;
    cmpVal[CMP_EQ_BIT]    = (opA == opB);
    cmpVal[CMP_GT_BIT]    = aGreater;
    cmpVal[CMP_LT_BIT]    = aLess;
    cmpVal[CMP_AZERO_BIT] = (opA == '0);
    cmpVal[CMP_BZERO_BIT] = (opB == '0);
  end

  always_comb begin
    unique case (strobes.resSel)
      SEL_ADD:   nextResult = opA + opB;
      SEL_SUB:   nextResult = opA - opB;
      SEL_OR:    nextResult = opA | opB;
      SEL_XOR:   nextResult = opA ^ opB;
      SEL_AND:   nextResult = opA & opB;
      SEL_NOT:   nextResult = ~opA;
      SEL_PASSA: nextResult = opA;
      SEL_LOAD:  nextResult = loadVal;
      SEL_CMP:   nextResult = cmpVal;
      SEL_SHL:   nextResult = opA << shAmt;
      SEL_SHR:   nextResult = opA >> shAmt;
      default:   nextResult = '0;
    endcase
  end

  assign nextTaken  = strobes.jumpAlways | (strobes.jumpCond & opB[CMP_EQ_BIT]);
  assign nextTarget = !nextTaken ? '0 : (strobes.tgtImm ? immVal : opA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      branchTaken  <= 1'b0;
      branchTarget <= '0;
      regWrite     <= 1'b0;
    end else if (en) begin
      result       <= nextResult;
      branchTaken  <= nextTaken;
      branchTarget <= nextTarget;
      regWrite     <= strobes.wrReg;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(result) && $stable(branchTaken) && $stable(branchTarget) && $stable(regWrite))); // R2

  AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> !regWrite); // R10

  AST_TARGET_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !branchTaken |-> (branchTarget == '0)); // R8

  AST_CMP_ONE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobes.resSel == SEL_CMP) |=>
      ($onehot0(result[CMP_LT_BIT:CMP_EQ_BIT]) && (result[DATA_W-1:CMP_BITS] == '0))); // R6

  AST_LOAD_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (en && strobes.resSel == SEL_LOAD) |=>
      ((result[DATA_W-1:HALF_W] == '0) || (result[HALF_W-1:0] == '0))); // R5

endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int OP_W  = OPC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [OP_W-1:0]   aluOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] immVal,
  output logic [DATA_W-1:0] result,
  output logic              branchTaken,
  output logic [DATA_W-1:0] branchTarget,
  output logic              regWrite
);

  ctrlStrobes_t strobes;

  alu16_ctrl #(.OP_W(OP_W)) u_ctrl (
    .aluOp   (aluOp),
    .strobes (strobes)
  );

  alu16_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .en           (en),
    .strobes      (strobes),
    .opA          (opA),
    .opB          (opB),
    .immVal       (immVal),
    .result       (result),
    .branchTaken  (branchTaken),
    .branchTarget (branchTarget),
    .regWrite     (regWrite)
  );

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (en && aluOp[OP_W-1:OP_W-3] == 3'b111) |=>
      ((result == '0) && !branchTaken && !regWrite)); // R11

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (en && aluOp[OP_W-1:1] == OPC_JMP) |=> branchTaken); // R8

endmodule

// File: tb/alu16_exec_bench.sv
module alu16_exec_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  aluOp = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [15:0] immVal = '0;
  logic [15:0] result;
  logic        branchTaken;
  logic [15:0] branchTarget;
  logic        regWrite;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] expRes = '0;
  logic        expTk = 1'b0;
  logic [15:0] expTg = '0;
  logic        expWr = 1'b0;
  string       expTag = "R1";

  always #2 clk = ~clk;

  alu16_exec u_alu16_exec (
    .clk(clk), .rstN(rstN), .en(en), .aluOp(aluOp), .opA(opA), .opB(opB),
    .immVal(immVal), .result(result), .branchTaken(branchTaken),
    .branchTarget(branchTarget), .regWrite(regWrite)
  );

  function automatic string tagOf(input logic [4:0] op);
    case (op[4:1])
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return "R3";
      4'd6, 4'd7:   return "R7";
      4'd8:         return "R5";
      4'd9:         return "R6";
      4'd10, 4'd11: return "R4";
      4'd12:        return "R8";
      4'd13:        return "R9";
      default:      return "R11";
    endcase
  endfunction

  task automatic model(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] imm, output logic [15:0] r, output logic tk,
                       output logic [15:0] tg, output logic wr);
    int sh;
    logic flag;
    flag = op[0];
    sh = int'(b % 16);
    r = 16'h0; tk = 1'b0; tg = 16'h0; wr = 1'b1;
    case (op[4:1])
      4'd0:  r = 16'((int'(a) + int'(b)) % 65536);
      4'd1:  r = 16'((int'(a) - int'(b) + 65536) % 65536);
      4'd2:  r = a | b;
      4'd3:  r = a ^ b;
      4'd4:  r = a & b;
      4'd5:  r = 16'hFFFF - a;
      4'd6:  r = a;
      4'd7:  begin r = a; wr = 1'b0; end
      4'd8:  r = flag ? {imm[15:8], 8'h00} : {8'h00, imm[7:0]};
      4'd9:  begin
        int sa, sb;
        sa = flag ? (int'(a) >= 32768 ? int'(a) - 65536 : int'(a)) : int'(a);
        sb = flag ? (int'(b) >= 32768 ? int'(b) - 65536 : int'(b)) : int'(b);
        r[0] = (sa == sb);
        r[1] = (sa > sb);
        r[2] = (sa < sb);
        r[3] = (a == 16'h0);
        r[4] = (b == 16'h0);
      end
      4'd10: r = 16'((int'(a) * (1 << sh)) % 65536);
      4'd11: r = 16'(int'(a) / (1 << sh));
      4'd12: begin wr = 1'b0; tk = 1'b1; tg = flag ? imm : a; end
      4'd13: begin wr = 1'b0; tk = b[0]; tg = b[0] ? a : 16'h0; end
      default: wr = 1'b0;
    endcase
  endtask

  task automatic checkVal(input string tag, input string name, input logic [15:0] act,
                          input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  // Called at a negedge: compare outputs, then apply the next stimulus
  task automatic step(input logic e, input logic [4:0] op, input logic [15:0] a,
                      input logic [15:0] b, input logic [15:0] imm);
    @(negedge clk);
    checkVal(expTag, "result", result, expRes);
    checkVal(expTag, "branchTaken", {15'h0, branchTaken}, {15'h0, expTk});
    checkVal(expTag, "branchTarget", branchTarget, expTg);
    checkVal(expTag, "regWrite", {15'h0, regWrite}, {15'h0, expWr});
    if (e && rstN) begin
      model(op, a, b, imm, expRes, expTk, expTg, expWr);
      expTag = (op[4:1] == 4'd7 || op[4:1] == 4'd12 || op[4:1] == 4'd13) ? "R10" : tagOf(op);
      if (op[4:1] < 4'd7) expTag = tagOf(op);
    end else if (rstN) begin
      expTag = "R2";
    end
    en = e; aluOp = op; opA = a; opB = b; immVal = imm;
  endtask

  function automatic logic [15:0] dup(input logic [7:0] v);
    return {v, v};
  endfunction

  initial begin
    // R1: reset state, with en held high and inputs live
    expTag = "R1";
    step(1'b1, 5'b00000, 16'h1234, 16'h1111, 16'h0);
    step(1'b1, 5'b10001, 16'hFFFF, 16'h0001, dup(8'h77));
    step(1'b0, 5'b0, 16'h0, 16'h0, 16'h0);
    rstN = 1'b1;
    // R3 arithmetic wrap and logic
    step(1'b1, {4'd0, 1'b0}, 16'hFFFF, 16'h0001, 16'h0);
    step(1'b1, {4'd1, 1'b1}, 16'h0000, 16'h0001, 16'h0);
    step(1'b1, {4'd2, 1'b0}, 16'hA0A0, 16'h0A0A, 16'h0);
    step(1'b1, {4'd3, 1'b0}, 16'hFF00, 16'h0FF0, 16'h0);
    step(1'b1, {4'd4, 1'b0}, 16'hF0F0, 16'h3C3C, 16'h0);
    step(1'b1, {4'd5, 1'b0}, 16'h00FF, 16'hAAAA, 16'h0);
    // R4 shifts: zero, max, upper bits of B ignored
    step(1'b1, {4'd10, 1'b0}, 16'h8001, 16'h0000, 16'h0);
    step(1'b1, {4'd10, 1'b0}, 16'h0003, 16'h000F, 16'h0);
    step(1'b1, {4'd11, 1'b1}, 16'h8000, 16'h0013, 16'h0);
    step(1'b1, {4'd11, 1'b0}, 16'hFFFF, 16'h000F, 16'h0);
    // R5 load lanes
    step(1'b1, {4'd8, 1'b1}, 16'h0, 16'h0, dup(8'hA5));
    step(1'b1, {4'd8, 1'b0}, 16'h0, 16'h0, dup(8'h5C));
    // R6 compare: signedness on sign bit, equality, zeros
    step(1'b1, {4'd9, 1'b1}, 16'h8000, 16'h0001, 16'h0);
    step(1'b1, {4'd9, 1'b0}, 16'h8000, 16'h0001, 16'h0);
    step(1'b1, {4'd9, 1'b0}, 16'h0000, 16'h0000, 16'h0);
    step(1'b1, {4'd9, 1'b1}, 16'hFFFF, 16'hFFFE, 16'h0);
    // R7 memory address pass-through
    step(1'b1, {4'd6, 1'b0}, 16'h001F, 16'hBEEF, 16'h0);
    step(1'b1, {4'd7, 1'b0}, 16'h0020, 16'hCAFE, 16'h0);
    // R8 jumps both sources, R9 conditional
    step(1'b1, {4'd12, 1'b1}, 16'h1234, 16'h0, dup(8'h3C));
    step(1'b1, {4'd12, 1'b0}, 16'h1234, 16'h0, dup(8'h3C));
    step(1'b1, {4'd13, 1'b0}, 16'h0440, 16'h0001, dup(8'h11));
    step(1'b1, {4'd13, 1'b1}, 16'h0440, 16'h0002, dup(8'h11));
    // R11 reserved codes both flags
    step(1'b1, {4'd14, 1'b0}, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    step(1'b1, {4'd15, 1'b1}, 16'hFFFF, 16'h0001, 16'hFFFF);
    // R2 hold while en low after a non-zero result
    step(1'b1, {4'd0, 1'b0}, 16'h0100, 16'h0023, 16'h0);
    step(1'b0, {4'd12, 1'b1}, 16'h9999, 16'h1, 16'hFFFF);
    step(1'b0, {4'd5, 1'b0}, 16'h0000, 16'h1, 16'h0);
    // Random operations with random enable
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 5'($urandom), 16'($urandom), 16'($urandom), dup(8'($urandom)));
    end
    step(1'b0, 5'b0, 16'h0, 16'h0, 16'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule